// File: doc/BRIEF.md
# Four-Phase Parallel Bus Responder

This block is the answering end of a byte-wide parallel link that runs a four-phase handshake. The far side raises a command strobe together with a direction select. This block raises the acknowledge when its half of the transfer is done. The far side then drops the strobe, and this block drops the acknowledge. The shared 8-bit bus is modelled as three separate signals: data in, data out and an output enable. The block turns the bus around itself, and it drives the bus only while it answers a read.

The strobe and the direction select come from another clock domain, so each passes through a two-flop synchronizer. The direction is taken once, when the strobe is first seen high.

A write hands the received byte to local logic as a one-cycle pulse. A read waits until local logic presents a valid result. Until then the acknowledge stays low, which stalls the far side for as long as the result takes. The data is placed on the bus one clock before the acknowledge rises. It is withdrawn in the same clock that the acknowledge falls.

Top module: `hs4_bus_slave`

## Requirements
- R1: During reset and in the first cycle after it, `ack_o`, `bus_oe_o` and `wr_valid_o` are all 0.
- R2: A write is selected by `rnw_i` = 0 when the strobe is first seen. It produces exactly one `wr_valid_o` pulse, one cycle long, with `wr_data_o` equal to `bus_din_i`. `ack_o` is still 0 in that cycle and rises in the next cycle.
- R3: A read is selected by `rnw_i` = 1. While `bus_oe_o` is 1, `bus_dout_o` equals the `rd_data_i` byte that was present when `rd_valid_i` was accepted, and it does not change.
- R4: On a read, `bus_oe_o` is already 1 in the cycle before `ack_o` rises.
- R5: `ack_o` falls only after `cmd_i` has gone low. In the cycle where `ack_o` is first 0, `bus_oe_o` is also 0.
- R6: `bus_oe_o` is never 1 during a write transfer.
- R7: During a read, `ack_o` and `bus_oe_o` stay 0 for as long as `rd_valid_i` is 0.
- R8: The direction is taken once, when the strobe is first seen high. Later changes of `rnw_i` within the same transfer have no effect.
- R9: `wr_data_o` keeps the last written byte. Changes on `bus_din_i` after the byte has been captured do not alter it.
- R10: After the transfer completes, `ack_o` and `bus_oe_o` return to 0 and a new strobe starts a fresh transfer. If reset is asserted in the middle of a transfer, both outputs return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 1 | Command strobe from the far side (asynchronous) |
| rnw_i | input | 1 | Direction select: 1 means read, 0 means write (asynchronous) |
| ack_o | output | 1 | Acknowledge to the far side |
| bus_din_i | input | 8 | Value seen on the shared bus |
| bus_dout_o | output | 8 | Value this block drives onto the bus |
| bus_oe_o | output | 1 | Drive enable for the bus |
| wr_valid_o | output | 1 | One-cycle pulse that marks a received byte |
| wr_data_o | output | 8 | Last received byte |
| rd_valid_i | input | 1 | Local result is ready |
| rd_data_i | input | 8 | Local result byte |

## Verification
The hardest situation to reach from the ports is a read that is stalled for a long time while its inputs change during the stall. The bench holds `rd_valid_i` low for several cycles after the strobe and flips `rnw_i` during that window. It then confirms that the read still completes, with `ack_o` and `bus_oe_o` low until the result arrives. The bus lead is checked at the rising edge of the acknowledge by remembering the enable from the previous cycle. A reset asserted while the acknowledge is high is also exercised.

// File: rtl/hs4_pkg.sv
// Package: shared types of the four-phase bus responder.
// Assumes: nothing beyond the standard language.
package hs4_pkg;
    localparam int BUS_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WR_CAP = 3'd1,
        ST_RD_WT  = 3'd2,
        ST_RD_SET = 3'd3,
        ST_ACKED  = 3'd4
    } hs4_state_t;
endpackage

// File: rtl/hs4_sync.sv
// Module: multi-bit, multi-stage flop synchronizer for level signals.
// Assumes: each bit is an independent slow level, so the bits need not stay coherent with one another.
module hs4_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: move each bit one flop further down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[g] <= '0;
                end else if (g == 0) begin
                    stage_q[g] <= async_i;
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/hs4_ctrl.sv
// Module: handshake sequencer for the responder.
// Assumes: cmd_s and rnw_s are already synchronized. The far side keeps the bus stable
// from before the strobe rises until the acknowledge is seen.
module hs4_ctrl
    import hs4_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_s,
    input  logic rnw_s,
    input  logic rd_valid_i,
    output logic ack_o,
    output logic oe_o,
    output logic dir_rd_o,
    output logic cap_wr_o,
    output logic cap_rd_o
);
    hs4_state_t state_q, state_d;
    logic       ack_d, oe_d, dir_d;
    logic       ack_q, oe_q, dir_q;

    // Purpose: choose the next state and the next values of the output flops.
    always_comb begin
        state_d  = state_q;
        ack_d    = ack_q;
        oe_d     = oe_q;
        dir_d    = dir_q;
        cap_wr_o = 1'b0;
        cap_rd_o = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (cmd_s) begin
                    dir_d = rnw_s;
                    if (rnw_s) begin
                        state_d = ST_RD_WT;
                    end else begin
                        cap_wr_o = 1'b1;
                        state_d  = ST_WR_CAP;
                    end
                end
            end
            ST_WR_CAP: begin
                ack_d   = 1'b1;
                state_d = ST_ACKED;
            end
            ST_RD_WT: begin
                if (rd_valid_i) begin
                    cap_rd_o = 1'b1;
                    oe_d     = 1'b1;
                    state_d  = ST_RD_SET;
                end
            end
            ST_RD_SET: begin
                ack_d   = 1'b1;
                state_d = ST_ACKED;
            end
            ST_ACKED: begin
                if (!cmd_s) begin
                    ack_d   = 1'b0;
                    oe_d    = 1'b0;
                    dir_d   = 1'b0;
                    state_d = ST_IDLE;
                end
            end
            default: begin
                ack_d   = 1'b0;
                oe_d    = 1'b0;
                dir_d   = 1'b0;
                state_d = ST_IDLE;
            end
        endcase
    end

    // Purpose: hold the state and the registered handshake outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ack_q   <= 1'b0;
            oe_q    <= 1'b0;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ack_q   <= ack_d;
            oe_q    <= oe_d;
            dir_q   <= dir_d;
        end
    end

    assign ack_o    = ack_q;
    assign oe_o     = oe_q;
    assign dir_rd_o = dir_q;
endmodule

// File: rtl/hs4_datapath.sv
// Module: byte registers for the received byte and for the result driven onto the bus.
// Assumes: the capture strobes come from the sequencer and last one cycle each.
module hs4_datapath #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_wr_i,
    input  logic             cap_rd_i,
    input  logic [WIDTH-1:0] bus_din_i,
    input  logic [WIDTH-1:0] rd_data_i,
    output logic [WIDTH-1:0] bus_dout_o,
    output logic             wr_valid_o,
    output logic [WIDTH-1:0] wr_data_o
);
    logic [WIDTH-1:0] wr_q, rd_q;
    logic             wv_q;

    // Purpose: capture the bus byte on a write and raise the one-cycle delivery pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
            wv_q <= 1'b0;
        end else begin
            wv_q <= cap_wr_i;
            if (cap_wr_i) wr_q <= bus_din_i;
        end
    end

    // Purpose: hold the local result that is driven during a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (cap_rd_i) begin
            rd_q <= rd_data_i;
        end
    end

    assign bus_dout_o = rd_q;
    assign wr_valid_o = wv_q;
    assign wr_data_o  = wr_q;
endmodule

// File: rtl/hs4_bus_slave.sv
// Module: top of the four-phase parallel bus responder.
// Assumes: cmd_i and rnw_i are asynchronous. bus_din_i is stable whenever the strobe is high
// on a write. rd_valid_i stays high until local logic sees ack_o.
module hs4_bus_slave
    import hs4_pkg::*;
#(
    parameter int DW        = BUS_W,
    parameter int SYNC_DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_i,
    input  logic          rnw_i,
    output logic          ack_o,
    input  logic [DW-1:0] bus_din_i,
    output logic [DW-1:0] bus_dout_o,
    output logic          bus_oe_o,
    output logic          wr_valid_o,
    output logic [DW-1:0] wr_data_o,
    input  logic          rd_valid_i,
    input  logic [DW-1:0] rd_data_i
);
    localparam int CTRL_W = 2;

    logic [CTRL_W-1:0] ctl_sync;
    logic              cmd_s, rnw_s;
    logic              dir_rd, cap_wr, cap_rd;

    hs4_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cmd_i, rnw_i}),
        .sync_o  (ctl_sync)
    );

    assign cmd_s = ctl_sync[1];
    assign rnw_s = ctl_sync[0];

    hs4_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_s      (cmd_s),
        .rnw_s      (rnw_s),
        .rd_valid_i (rd_valid_i),
        .ack_o      (ack_o),
        .oe_o       (bus_oe_o),
        .dir_rd_o   (dir_rd),
        .cap_wr_o   (cap_wr),
        .cap_rd_o   (cap_rd)
    );

    hs4_datapath #(.WIDTH(DW)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_wr_i   (cap_wr),
        .cap_rd_i   (cap_rd),
        .bus_din_i  (bus_din_i),
        .rd_data_i  (rd_data_i),
        .bus_dout_o (bus_dout_o),
        .wr_valid_o (wr_valid_o),
        .wr_data_o  (wr_data_o)
    );
endmodule

// File: rtl/hs4_bus_slave_chk.sv
// Module: property checker for the responder, attached through bind.
// Assumes: it is connected to the top-level ports and to the synchronized strobe and direction.
module hs4_bus_slave_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_s,
    input logic          dir_rd,
    input logic          ack_o,
    input logic          bus_oe_o,
    input logic [DW-1:0] bus_dout_o,
    input logic          wr_valid_o
);
    AST_WR_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |=> !wr_valid_o) else $error("wr pulse too long"); // R2
    AST_WR_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> !ack_o ##1 ack_o) else $error("ack order on write"); // R2
    AST_DOUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_o && $past(bus_oe_o)) |-> $stable(bus_dout_o)) else $error("dout moved"); // R3
    AST_OE_LEADS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ack_o) && dir_rd) |-> $past(bus_oe_o)) else $error("oe late"); // R4
    AST_ACK_FALL_CMD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_o) |-> $past(!cmd_s)) else $error("ack fell early"); // R5
    AST_OE_DROPS_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_o) |-> !bus_oe_o) else $error("oe held"); // R5
    AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o |-> dir_rd) else $error("drove on write"); // R6
endmodule

bind hs4_bus_slave hs4_bus_slave_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_s      (cmd_s),
    .dir_rd     (dir_rd),
    .ack_o      (ack_o),
    .bus_oe_o   (bus_oe_o),
    .bus_dout_o (bus_dout_o),
    .wr_valid_o (wr_valid_o)
);

// File: tb/hs4_bus_slave_tb.sv
`timescale 1ns/1ps
module hs4_bus_slave_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_i = 1'b0, rnw_i = 1'b0, rd_valid_i = 1'b0;
    logic [7:0] bus_din_i = 8'h00, rd_data_i = 8'h00;
    logic       ack_o, bus_oe_o, wr_valid_o;
    logic [7:0] bus_dout_o, wr_data_o;

    int checks = 0;
    int errors = 0;
    logic in_write = 1'b0;
    logic in_read  = 1'b0;
    logic oe_in_write = 1'b0;
    logic prev_ack = 1'b0, prev_oe = 1'b0;

    always #4 clk = ~clk;

    hs4_bus_slave u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .rnw_i(rnw_i), .ack_o(ack_o),
        .bus_din_i(bus_din_i), .bus_dout_o(bus_dout_o), .bus_oe_o(bus_oe_o),
        .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o),
        .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bus monitors sampled away from the active edge.
    always @(negedge clk) begin
        if (in_write && bus_oe_o) oe_in_write <= 1'b1;
        if (rst_n && in_read && ack_o && !prev_ack)
            check(prev_oe, "R4 oe before ack", prev_oe, 1);
        prev_ack <= ack_o;
        prev_oe  <= bus_oe_o;
    end

    task automatic wait_for(input logic want, input int which, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (which == 0 && ack_o == want) begin ok = 1'b1; break; end
            if (which == 1 && wr_valid_o == want) begin ok = 1'b1; break; end
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        bit ok;
        logic ack_at_pulse;
        in_write = 1'b1; oe_in_write = 1'b0;
        @(negedge clk);
        bus_din_i = d; rnw_i = 1'b0;
        @(negedge clk);
        cmd_i = 1'b1;
        wait_for(1'b1, 1, ok);
        ack_at_pulse = ack_o;
        check(ok && wr_data_o == d, "R2 write byte", wr_data_o, d);
        check(!ack_at_pulse, "R2 ack low during pulse", ack_at_pulse, 0);
        @(negedge clk);
        check(!wr_valid_o && ack_o, "R2 pulse ends and ack rises", {wr_valid_o, ack_o}, 1);
        bus_din_i = ~d;
        repeat (3) @(negedge clk);
        check(ack_o, "R5 ack held while cmd high", ack_o, 1);
        cmd_i = 1'b0;
        wait_for(1'b0, 0, ok);
        check(ok && !bus_oe_o, "R5 ack falls, oe low", bus_oe_o, 0);
        check(wr_data_o == d, "R9 byte held", wr_data_o, d);
        check(!oe_in_write, "R6 no drive on write", oe_in_write, 0);
        in_write = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] r, input int stall);
        bit ok;
        bit quiet = 1'b1;
        in_read = 1'b1;
        @(negedge clk);
        rnw_i = 1'b1;
        rd_valid_i = (stall == 0);
        rd_data_i = r;
        @(negedge clk);
        cmd_i = 1'b1;
        if (stall > 0) begin
            for (int i = 0; i < stall + 4; i++) begin
                @(negedge clk);
                if (i == 3) rnw_i = 1'b0;
                if (ack_o || bus_oe_o) quiet = 1'b0;
            end
            check(quiet, "R7 stalled read quiet", {ack_o, bus_oe_o}, 0);
            rd_valid_i = 1'b1;
        end
        wait_for(1'b1, 0, ok);
        check(ok && bus_oe_o && bus_dout_o == r, "R3 read result driven", bus_dout_o, r);
        if (stall > 0) check(ok && bus_oe_o, "R8 direction kept", bus_oe_o, 1);
        rd_valid_i = 1'b0;
        rd_data_i = ~r;
        repeat (2) @(negedge clk);
        check(bus_dout_o == r && bus_oe_o, "R3 result stable", bus_dout_o, r);
        cmd_i = 1'b0;
        wait_for(1'b0, 0, ok);
        check(ok && !bus_oe_o, "R5 release with ack", bus_oe_o, 0);
        rnw_i = 1'b0;
        in_read = 1'b0;
    endtask

    // {rnw, data/result, stall}
    localparam logic [12:0] VEC [8] = '{
        {1'b0, 8'h20, 4'd0}, {1'b1, 8'h21, 4'd0}, {1'b0, 8'hFF, 4'd0}, {1'b1, 8'h00, 4'd5},
        {1'b0, 8'h00, 4'd0}, {1'b1, 8'hA5, 4'd9}, {1'b0, 8'h5A, 4'd0}, {1'b1, 8'hFF, 4'd2}
    };

    initial begin
        bit ok;
        repeat (3) @(negedge clk);
        check(!ack_o && !bus_oe_o && !wr_valid_o, "R1 in reset", {ack_o, bus_oe_o, wr_valid_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!ack_o && !bus_oe_o && !wr_valid_o, "R1 after reset", {ack_o, bus_oe_o, wr_valid_o}, 0);

        foreach (VEC[i]) begin
            if (VEC[i][12]) do_read(VEC[i][11:4], int'(VEC[i][3:0]));
            else            do_write(VEC[i][11:4]);
        end

        // R10: reset in the middle of a read while the bus is driven.
        in_read = 1'b1;
        rnw_i = 1'b1; rd_valid_i = 1'b1; rd_data_i = 8'h3C;
        @(negedge clk); cmd_i = 1'b1;
        wait_for(1'b1, 0, ok);
        check(ok && bus_oe_o, "R10 read reached ack", bus_oe_o, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(!ack_o && !bus_oe_o, "R10 mid-transfer reset", {ack_o, bus_oe_o}, 0);
        cmd_i = 1'b0; rd_valid_i = 1'b0; rnw_i = 1'b0; in_read = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        do_write(8'h77);
        check(wr_data_o == 8'h77, "R10 fresh transfer after reset", wr_data_o, 8'h77);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        checks++; errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule